// File: doc/BRIEF.md
# Thermal Window Comparator Interrupt Logic

This block sits behind a temperature converter and turns each finished sample into alarm state. Every sample is a 10-bit two's-complement value with a resolution of half a degree. The block compares each sample with three programmable limits: a lower window edge, an upper window edge and a critical level. All three limits share one hysteresis value. For the two upper limits the hysteresis is subtracted from the limit, and for the lower limit it is added. The block keeps one sticky status flag per limit. It drives two alarms, a window interrupt and a critical alarm, as open-drain pull-down enables whose sense is programmable.

The window interrupt has two modes. In level (comparator) mode it is re-evaluated from the window flags at every conversion. In event mode it latches on every change of a window flag and stays set until a register read clears it. An optional fault filter requires several consecutive out-of-limit samples before a flag may be set. A shutdown control stops all comparisons and releases both alarms. A read strobe from the register interface clears the alarms and asks the converter to restart.

Top module: `thermwin_alarm`

## Requirements
- R1: The high and critical flags are set on a conversion whose sample is strictly above their limit. They are cleared only on a conversion whose sample is strictly below the limit minus the hysteresis. Between those two points they hold their value. All arithmetic is signed and one bit wider than a sample, so it cannot wrap.
- R2: The low flag is set on a conversion whose sample is strictly below the low limit. It is cleared only on a conversion whose sample is strictly above the low limit plus the hysteresis. Negative limits and samples are compared as signed values.
- R3: The flags change only at a clock edge where `conv_vld` is 1 and `cfg_sdn` is 0. A read strobe and limit changes have no effect on them.
- R4: In level mode (`cfg_event`=0), every conversion sets the window interrupt to the OR of the low and high flags after that conversion. A read clears the interrupt, and it stays clear until the next conversion.
- R5: In event mode (`cfg_event`=1), a conversion that changes the low or the high flag sets the window interrupt. The interrupt then stays set until a read. After a read it stays clear, even while a condition is still true, until a flag changes again.
- R6: In both modes, every conversion sets the critical alarm equal to the critical flag. A read clears the critical alarm until the next conversion.
- R7: With `cfg_fq_en`=1, a clear flag is set only on the 4th consecutive conversion whose sample trips it. A conversion that does not trip the flag resets the count, and so does a cycle with the filter disabled. Clearing a flag is never filtered.
- R8: Each enable equals the alarm state XOR its polarity bit. With polarity 0 (active low) an active alarm drives the pin (enable 1). With polarity 1 (active high) an inactive alarm drives the pin. After reset all flags are 0 and both alarms are inactive.
- R9: While `cfg_sdn`=1, both alarms are inactive from the next edge on. Conversions are ignored and the fault counts are reset.
- R10: A read in the same cycle as a conversion clears both alarms, while the flags still take the new conversion.
- R11: A read while not shut down makes `restart_req` 1 for the one cycle after the read's edge. Otherwise `restart_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_vld | input | 1 | One-cycle strobe: a conversion finished |
| conv_temp | input | TW | Converted sample, two's complement, 0.5 degree units |
| lim_low | input | TW | Lower window limit |
| lim_high | input | TW | Upper window limit |
| lim_crit | input | TW | Critical limit |
| hyst | input | TW | Shared hysteresis |
| cfg_event | input | 1 | 0 level mode, 1 event mode |
| cfg_int_pol | input | 1 | Window interrupt polarity (0 active low) |
| cfg_crit_pol | input | 1 | Critical alarm polarity (0 active low) |
| cfg_fq_en | input | 1 | Consecutive-fault filter enable |
| cfg_sdn | input | 1 | Shutdown |
| rd_pulse | input | 1 | One-cycle strobe: a register was read |
| flg_low | output | 1 | Low status flag |
| flg_high | output | 1 | High status flag |
| flg_crit | output | 1 | Critical status flag |
| int_oe | output | 1 | Pull-down enable for the window interrupt pin |
| crit_oe | output | 1 | Pull-down enable for the critical alarm pin |
| restart_req | output | 1 | Request to restart the converter |

## Verification
Some properties are checked by assertions on every cycle:
- the flags hold whenever no conversion is accepted;
- shutdown and reads leave both enables at their inactive level on the following cycle;
- the critical alarm is never active without its flag;
- in level mode the interrupt matches the window flags after each accepted conversion;
- a read raises the restart request.

Other behaviour shows only through the bench scenarios, scored against a behavioural reference model:
- the exact hysteresis thresholds, including the signed negative range;
- the event-mode rule that a read keeps the interrupt clear while the condition persists;
- the fourth-sample rule of the fault filter and the resets of its count.

// File: rtl/thermwin_pkg.sv
package thermwin_pkg;

   // which side of the limit trips a flag
   typedef enum logic {
      LIM_UPPER = 1'b0,
      LIM_LOWER = 1'b1
   } lim_dir_e;

   localparam int NLIM     = 3;
   localparam int IDX_LOW  = 0;
   localparam int IDX_HIGH = 1;
   localparam int IDX_CRIT = 2;

endpackage

// File: rtl/thermwin_flag.sv
module thermwin_flag
   import thermwin_pkg::*;
#(
   parameter int       TW     = 10,
   parameter int       QDEPTH = 4,
   parameter lim_dir_e DIR    = LIM_UPPER
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_en,
   input  logic          cnt_clr,
   input  logic          fq_en,
   input  logic [TW-1:0] sample,
   input  logic [TW-1:0] limit,
   input  logic [TW-1:0] hyst,
   output logic          flag_q,
   output logic          flag_d
);

   localparam int XW = TW + 1;
   localparam int CW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(QDEPTH - 1);

   logic signed [XW-1:0] s_x, lim_x, hys_x, rel_x;
   logic                 trip, release_c;
   logic [CW-1:0]        cnt_q, cnt_d;

   assign s_x   = {sample[TW-1], sample};
   assign lim_x = {limit[TW-1], limit};
   assign hys_x = {hyst[TW-1], hyst};

   generate
      if (DIR == LIM_UPPER) begin : g_upper
         assign rel_x     = lim_x - hys_x;
         assign trip      = s_x > lim_x;
         assign release_c = s_x < rel_x;
      end else begin : g_lower
         assign rel_x     = lim_x + hys_x;
         assign trip      = s_x < lim_x;
         assign release_c = s_x > rel_x;
      end
   endgenerate

   always_comb begin
      flag_d = flag_q;
      cnt_d  = cnt_clr ? '0 : cnt_q;
      if (conv_en) begin
         if (!flag_q) begin
            if (trip) begin
               if (!fq_en || cnt_q == CNT_LAST) begin
                  flag_d = 1'b1;
                  cnt_d  = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end else begin
               cnt_d = '0;
            end
         end else begin
            cnt_d = '0;
            if (release_c) flag_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         flag_q <= flag_d;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/thermwin_irq.sv
module thermwin_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic sdn,
   input  logic rd,
   input  logic conv_en,
   input  logic evt_mode,
   input  logic win_now,
   input  logic win_chg,
   input  logic crit_now,
   input  logic int_pol,
   input  logic crit_pol,
   output logic int_oe,
   output logic crit_oe
);

   logic int_act, crit_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_act  <= 1'b0;
         crit_act <= 1'b0;
      end else if (sdn || rd) begin
         int_act  <= 1'b0;
         crit_act <= 1'b0;
      end else if (conv_en) begin
         crit_act <= crit_now;
         if (evt_mode) begin
            if (win_chg) int_act <= 1'b1;
         end else begin
            int_act <= win_now;
         end
      end
   end

   // open drain: pin driven low when enable is 1
   assign int_oe  = int_act ^ int_pol;
   assign crit_oe = crit_act ^ crit_pol;

endmodule

// File: rtl/thermwin_alarm.sv
module thermwin_alarm
   import thermwin_pkg::*;
#(
   parameter int TW     = 10,
   parameter int QDEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_vld,
   input  logic [TW-1:0] conv_temp,
   input  logic [TW-1:0] lim_low,
   input  logic [TW-1:0] lim_high,
   input  logic [TW-1:0] lim_crit,
   input  logic [TW-1:0] hyst,
   input  logic          cfg_event,
   input  logic          cfg_int_pol,
   input  logic          cfg_crit_pol,
   input  logic          cfg_fq_en,
   input  logic          cfg_sdn,
   input  logic          rd_pulse,
   output logic          flg_low,
   output logic          flg_high,
   output logic          flg_crit,
   output logic          int_oe,
   output logic          crit_oe,
   output logic          restart_req
);

   generate
      if (TW < 4) begin : g_bad_tw
         $error("thermwin_alarm: TW must be at least 4");
      end
      if (QDEPTH < 2) begin : g_bad_q
         $error("thermwin_alarm: QDEPTH must be at least 2");
      end
   endgenerate

   logic               conv_en, cnt_clr;
   logic [TW-1:0]      lim_arr [NLIM];
   logic [NLIM-1:0]    fl_q, fl_d;
   logic               rst_q;

   assign conv_en = conv_vld && !cfg_sdn;
   assign cnt_clr = cfg_sdn || !cfg_fq_en;

   assign lim_arr[IDX_LOW]  = lim_low;
   assign lim_arr[IDX_HIGH] = lim_high;
   assign lim_arr[IDX_CRIT] = lim_crit;

   generate
      for (genvar i = 0; i < NLIM; i++) begin : g_lim
         thermwin_flag #(
            .TW     (TW),
            .QDEPTH (QDEPTH),
            .DIR    ((i == IDX_LOW) ? LIM_LOWER : LIM_UPPER)
         ) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .conv_en (conv_en),
            .cnt_clr (cnt_clr),
            .fq_en   (cfg_fq_en),
            .sample  (conv_temp),
            .limit   (lim_arr[i]),
            .hyst    (hyst),
            .flag_q  (fl_q[i]),
            .flag_d  (fl_d[i])
         );
      end
   endgenerate

   thermwin_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sdn      (cfg_sdn),
      .rd       (rd_pulse),
      .conv_en  (conv_en),
      .evt_mode (cfg_event),
      .win_now  (fl_d[IDX_LOW] | fl_d[IDX_HIGH]),
      .win_chg  ((fl_d[IDX_LOW] ^ fl_q[IDX_LOW]) | (fl_d[IDX_HIGH] ^ fl_q[IDX_HIGH])),
      .crit_now (fl_d[IDX_CRIT]),
      .int_pol  (cfg_int_pol),
      .crit_pol (cfg_crit_pol),
      .int_oe   (int_oe),
      .crit_oe  (crit_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= rd_pulse && !cfg_sdn;
   end

   assign restart_req = rst_q;
   assign flg_low     = fl_q[IDX_LOW];
   assign flg_high    = fl_q[IDX_HIGH];
   assign flg_crit    = fl_q[IDX_CRIT];

endmodule

// File: rtl/thermwin_alarm_chk.sv
module thermwin_alarm_chk #(
   parameter int TW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          conv_vld,
   input logic [TW-1:0] conv_temp,
   input logic          cfg_event,
   input logic          cfg_int_pol,
   input logic          cfg_crit_pol,
   input logic          cfg_sdn,
   input logic          rd_pulse,
   input logic          flg_low,
   input logic          flg_high,
   input logic          flg_crit,
   input logic          int_oe,
   input logic          crit_oe,
   input logic          restart_req
);

   // R3
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_vld && !cfg_sdn) |=> $stable({flg_low, flg_high, flg_crit}));

   // R9
   sdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_sdn) |-> (int_oe == cfg_int_pol && crit_oe == cfg_crit_pol));

   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_pulse) |-> (int_oe == cfg_int_pol && crit_oe == cfg_crit_pol));

   // R6
   crit_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crit_oe != cfg_crit_pol) |-> flg_crit);

   // R4
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(conv_vld && !cfg_sdn && !cfg_event && !rd_pulse)
      |-> ((int_oe != cfg_int_pol) == (flg_low || flg_high)));

   // R11
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pulse && !cfg_sdn) |=> restart_req);

   // R11
   no_spurious_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pulse |=> !restart_req);

endmodule

bind thermwin_alarm thermwin_alarm_chk #(.TW(TW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_vld     (conv_vld),
   .conv_temp    (conv_temp),
   .cfg_event    (cfg_event),
   .cfg_int_pol  (cfg_int_pol),
   .cfg_crit_pol (cfg_crit_pol),
   .cfg_sdn      (cfg_sdn),
   .rd_pulse     (rd_pulse),
   .flg_low      (flg_low),
   .flg_high     (flg_high),
   .flg_crit     (flg_crit),
   .int_oe       (int_oe),
   .crit_oe      (crit_oe),
   .restart_req  (restart_req)
);

// File: tb/tb_thermwin_alarm.sv
module tb_thermwin_alarm;

   localparam int TW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_vld = 1'b0;
   logic [TW-1:0] conv_temp = '0;
   logic [TW-1:0] lim_low = 10'd20;
   logic [TW-1:0] lim_high = 10'd128;
   logic [TW-1:0] lim_crit = 10'd160;
   logic [TW-1:0] hyst = 10'd4;
   logic          cfg_event = 1'b0;
   logic          cfg_int_pol = 1'b0;
   logic          cfg_crit_pol = 1'b0;
   logic          cfg_fq_en = 1'b0;
   logic          cfg_sdn = 1'b0;
   logic          rd_pulse = 1'b0;
   logic          flg_low, flg_high, flg_crit, int_oe, crit_oe, restart_req;

   always #10 clk = ~clk;

   thermwin_alarm #(.TW(TW), .QDEPTH(4)) dut (.*);

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R8";

   // behavioural reference state
   int m_flag [3] = '{0, 0, 0};
   int m_cnt  [3] = '{0, 0, 0};
   int m_int = 0, m_crit = 0, m_rst = 0;

   function automatic int sx(logic [TW-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic model_step();
      int t, h, trip, rel;
      int lims [3];
      int nf   [3];
      t = sx(conv_temp);
      h = sx(hyst);
      lims[0] = sx(lim_low);
      lims[1] = sx(lim_high);
      lims[2] = sx(lim_crit);
      for (int i = 0; i < 3; i++) nf[i] = m_flag[i];
      if (!cfg_fq_en || cfg_sdn) for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      if (conv_vld && !cfg_sdn) begin
         for (int i = 0; i < 3; i++) begin
            if (i == 0) begin
               trip = (t < lims[i]) ? 1 : 0;
               rel  = (t > lims[i] + h) ? 1 : 0;
            end else begin
               trip = (t > lims[i]) ? 1 : 0;
               rel  = (t < lims[i] - h) ? 1 : 0;
            end
            if (m_flag[i] == 0) begin
               if (trip != 0) begin
                  if (!cfg_fq_en || m_cnt[i] == 3) begin
                     nf[i] = 1;
                     m_cnt[i] = 0;
                  end else m_cnt[i]++;
               end else m_cnt[i] = 0;
            end else begin
               m_cnt[i] = 0;
               if (rel != 0) nf[i] = 0;
            end
         end
      end
      if (cfg_sdn || rd_pulse) begin
         m_int = 0;
         m_crit = 0;
      end else if (conv_vld) begin
         m_crit = nf[2];
         if (cfg_event) begin
            if (nf[0] != m_flag[0] || nf[1] != m_flag[1]) m_int = 1;
         end else m_int = (nf[0] | nf[1]);
      end
      m_rst = (rd_pulse && !cfg_sdn) ? 1 : 0;
      for (int i = 0; i < 3; i++) m_flag[i] = nf[i];
   endtask

   task automatic compare();
      int e_int, e_crit;
      e_int  = m_int ^ int'(cfg_int_pol);
      e_crit = m_crit ^ int'(cfg_crit_pol);
      n_chk++;
      if (int'(flg_low) != m_flag[0] || int'(flg_high) != m_flag[1] ||
          int'(flg_crit) != m_flag[2] || int'(int_oe) != e_int ||
          int'(crit_oe) != e_crit || int'(restart_req) != m_rst) begin
         n_bad++;
         $display("FAIL %s model: got lo/hi/cr/int/crit/rst=%0d%0d%0d%0d%0d%0d exp=%0d%0d%0d%0d%0d%0d",
                  cur_req, flg_low, flg_high, flg_crit, int_oe, crit_oe, restart_req,
                  m_flag[0], m_flag[1], m_flag[2], e_int, e_crit, m_rst);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      #5;
      compare();
   endtask

   task automatic expect_b(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic conv(int t);
      conv_vld  = 1'b1;
      conv_temp = TW'(t);
      tick();
      conv_vld  = 1'b0;
   endtask

   task automatic rd();
      rd_pulse = 1'b1;
      tick();
      rd_pulse = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      rst_n = 1'b1;
      tick();
      // R8 reset state
      expect_b("R8", "reset flags", flg_low | flg_high | flg_crit, 1'b0);
      expect_b("R8", "reset int_oe", int_oe, 1'b0);
      expect_b("R8", "reset crit_oe", crit_oe, 1'b0);

      // R1 upper hysteresis: set >128, clear <124
      cur_req = "R1";
      conv(50);
      conv(130);  expect_b("R1", "hi set", flg_high, 1'b1);
      expect_b("R4", "level int on hi", int_oe, 1'b1);
      conv(124);  expect_b("R1", "hi hold at limit-hyst", flg_high, 1'b1);
      conv(123);  expect_b("R1", "hi clear", flg_high, 1'b0);
      expect_b("R4", "level int off", int_oe, 1'b0);

      // R2 lower hysteresis: set <20, clear >24
      cur_req = "R2";
      conv(20);   expect_b("R2", "lo not set at limit", flg_low, 1'b0);
      conv(10);   expect_b("R2", "lo set", flg_low, 1'b1);
      conv(24);   expect_b("R2", "lo hold at limit+hyst", flg_low, 1'b1);
      conv(25);   expect_b("R2", "lo clear", flg_low, 1'b0);
      lim_low = TW'(-20);
      tick();
      conv(-50);  expect_b("R2", "lo set negative", flg_low, 1'b1);
      conv(-17);  expect_b("R2", "lo hold negative", flg_low, 1'b1);
      conv(-15);  expect_b("R2", "lo clear negative", flg_low, 1'b0);
      lim_low = 10'd20;
      tick();

      // R4 / R3 read clears level interrupt, flags unaffected
      cur_req = "R4";
      conv(10);
      rd();
      expect_b("R4", "read clears int", int_oe, 1'b0);
      expect_b("R3", "read keeps lo flag", flg_low, 1'b1);
      tick(); tick();
      expect_b("R4", "stays clear until conversion", int_oe, 1'b0);
      conv(10);   expect_b("R4", "reasserted", int_oe, 1'b1);
      conv(50);

      // R6 critical alarm
      cur_req = "R6";
      conv(170);  expect_b("R6", "crit active", crit_oe, 1'b1);
      rd();       expect_b("R6", "read clears crit", crit_oe, 1'b0);
      expect_b("R3", "crit flag kept", flg_crit, 1'b1);
      conv(158);  expect_b("R6", "crit back", crit_oe, 1'b1);
      conv(155);  expect_b("R6", "crit released", crit_oe, 1'b0);
      conv(50);

      // R5 event mode
      cur_req = "R5";
      cfg_event = 1'b1;
      tick();
      conv(130);  expect_b("R5", "event on set", int_oe, 1'b1);
      rd();       expect_b("R5", "read clears", int_oe, 1'b0);
      conv(130);  expect_b("R5", "stays clear while true", int_oe, 1'b0);
      conv(126);  expect_b("R5", "no event inside hyst", int_oe, 1'b0);
      conv(120);  expect_b("R5", "event on release", int_oe, 1'b1);
      conv(50);   expect_b("R5", "latched without read", int_oe, 1'b1);
      rd();
      cfg_event = 1'b0;
      tick();

      // R7 fault filter
      cur_req = "R7";
      cfg_fq_en = 1'b1;
      tick();
      conv(130); conv(130); conv(130);
      expect_b("R7", "3 trips not enough", flg_high, 1'b0);
      conv(50);
      conv(130); conv(130); conv(130);
      expect_b("R7", "count reset by in-limit", flg_high, 1'b0);
      conv(130);  expect_b("R7", "4th trip sets", flg_high, 1'b1);
      conv(50);   expect_b("R7", "release unfiltered", flg_high, 1'b0);
      conv(130); conv(130);
      cfg_fq_en = 1'b0;
      tick();
      cfg_fq_en = 1'b1;
      tick();
      conv(130); conv(130); conv(130);
      expect_b("R7", "disable resets count", flg_high, 1'b0);
      conv(130);  expect_b("R7", "sets after 4", flg_high, 1'b1);
      conv(50);
      cfg_fq_en = 1'b0;
      tick();

      // R8 polarity
      cur_req = "R8";
      cfg_int_pol = 1'b1;
      cfg_crit_pol = 1'b1;
      tick();
      expect_b("R8", "inactive high drives", int_oe, 1'b1);
      conv(170);
      expect_b("R8", "active high releases int", int_oe, 1'b0);
      expect_b("R8", "active high releases crit", crit_oe, 1'b0);
      conv(50);
      cfg_int_pol = 1'b0;
      cfg_crit_pol = 1'b0;
      tick();

      // R9 shutdown
      cur_req = "R9";
      conv(130);
      cfg_sdn = 1'b1;
      tick();
      expect_b("R9", "sdn clears int", int_oe, 1'b0);
      conv(10);
      expect_b("R9", "no compare in sdn (hi)", flg_high, 1'b1);
      expect_b("R9", "no compare in sdn (lo)", flg_low, 1'b0);
      rd();
      expect_b("R11", "no restart in sdn", restart_req, 1'b0);
      cfg_sdn = 1'b0;
      tick();
      conv(50);

      // R10 / R11 read with conversion
      cur_req = "R10";
      rd_pulse = 1'b1;
      conv(130);
      rd_pulse = 1'b0;
      expect_b("R10", "flag updates", flg_high, 1'b1);
      expect_b("R10", "read wins on int", int_oe, 1'b0);
      expect_b("R11", "restart pulse", restart_req, 1'b1);
      tick();
      expect_b("R11", "restart one cycle", restart_req, 1'b0);
      conv(130);  expect_b("R10", "next conversion sets", int_oe, 1'b1);
      conv(50);
      repeat (4) tick();

      summary();
      $finish;
   end

endmodule